// File: doc/BRIEF.md
# Epoch-Ordered Persist Buffer

This block sits beside a core's first-level data cache. It keeps one entry for each store aimed at persistent memory, and it sends those entries to the memory controller on its own schedule, separate from cache writebacks. When the core retires a fence, the buffer records it as a marker that ends the current epoch. The memory controller receives no entry from a later epoch until every entry from the earlier epochs has been acknowledged as durable. Inside one epoch, entries may go out and be acknowledged in any order.

Coherence snoops can report that this core has observed a block whose persist is still waiting in another core's buffer. The next persistent store allocated here then carries a dependency on that remote entry ID. It is held back until the remote core's durable status vector shows that ID as acknowledged. The block publishes its own durable status vector, indexed by entry ID, for use by other cores. The core never waits for persists to complete. It is stalled only when it presents a persistent store or a fence and every slot is occupied.

Top module: `persist_buffer`

## Requirements
- R1: After reset, no entry is held, `drn_valid` and `stall` are low and `local_durable` is all zeros.
- R2: A store whose address has its most significant bit set is persistent. It takes one entry and is later offered on the drain port with its address and data. Its ID comes from a counter that starts at 0, increases by one for each persistent store and wraps modulo 2^ID_W.
- R3: A store whose address MSB is clear is volatile. It takes no entry, consumes no ID and never reaches the drain port.
- R4: While `drn_valid` is high and `drn_ready` is low, `drn_valid`, `drn_id`, `drn_addr` and `drn_data` hold their values.
- R5: A store accepted after a fence is not offered on the drain port until every persistent store accepted before that fence has been acknowledged.
- R6: Entries in the same epoch can be offered one after another while earlier ones are still unacknowledged, and they can be acknowledged in any order. Among ready entries, the lowest slot is offered first.
- R7: After a snoop dependency notice naming remote ID X, the next persistent store is not offered for drain until bit X of `remote_durable` is high.
- R8: `stall` is high only when a persistent store or a fence is presented while every slot is occupied. A fence takes a slot. A volatile store never stalls.
- R9: An acknowledge for an issued entry frees its slot and sets bit ID of `local_durable`. Allocating a new entry with that ID clears the bit.
- R10: A persistent store stalled by a full buffer is accepted in the cycle after an acknowledge frees a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store presented by the core |
| st_addr | input | ADDR_W | Store address; MSB set means persistent region |
| st_data | input | DATA_W | Store data |
| fence_valid | input | 1 | Retired fence presented by the core |
| snoop_dep_valid | input | 1 | Dependency notice from the coherence snoop path |
| snoop_dep_id | input | ID_W | Remote entry ID that the dependency names |
| remote_durable | input | 2^ID_W | Durable-acknowledged vector from the remote core |
| stall | output | 1 | Core must hold its store or fence |
| drn_valid | output | 1 | Drain request valid |
| drn_ready | input | 1 | Memory controller accepts the drain request |
| drn_id | output | ID_W | Entry ID of the drain request |
| drn_addr | output | ADDR_W | Block address of the drain request |
| drn_data | output | DATA_W | Data of the drain request |
| ack_valid | input | 1 | Memory controller reports a persist as durable |
| ack_id | input | ID_W | ID of the durable entry |
| local_durable | output | 2^ID_W | Durable-acknowledged vector for this core's IDs |

## Verification
The assertions assume that the core presents at most one of a store or a fence in any cycle, and that it holds a stalled request until it is accepted. They also assume that acknowledges name only entries that have already been issued. The bench drives stores and fences one at a time and keeps a stalled store asserted until `stall` falls. It acknowledges only IDs it has already taken from the drain port, so every check stays inside these conditions.

// File: rtl/pb_pkg.sv
package pb_pkg;
  typedef enum logic {
    KIND_STORE = 1'b0,
    KIND_FENCE = 1'b1
  } kind_e;
endpackage

// File: rtl/pb_pick.sv
module pb_pick #(
  parameter int N   = 8,
  localparam int W  = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req,
  output logic         any,
  output logic [W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = W'(i);
      end
    end
  end
endmodule

// File: rtl/pb_durable.sv
module pb_durable #(
  parameter int ID_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr_en,
  input  logic [ID_W-1:0]        clr_id,
  input  logic                   set_en,
  input  logic [ID_W-1:0]        set_id,
  output logic [(1<<ID_W)-1:0]   done
);
  for (genvar g = 0; g < (1 << ID_W); g++) begin : g_bit
    logic bit_d;
    logic bit_en;
    always_comb begin
      bit_en = (set_en && set_id == ID_W'(g)) || (clr_en && clr_id == ID_W'(g));
      bit_d  = set_en && set_id == ID_W'(g);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      done[g] <= 1'b0;
      else if (bit_en) done[g] <= bit_d;
    end
  end
endmodule

// File: rtl/persist_buffer.sv
module persist_buffer #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int ID_W   = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  st_valid,
  input  logic [ADDR_W-1:0]     st_addr,
  input  logic [DATA_W-1:0]     st_data,
  input  logic                  fence_valid,
  input  logic                  snoop_dep_valid,
  input  logic [ID_W-1:0]       snoop_dep_id,
  input  logic [(1<<ID_W)-1:0]  remote_durable,
  output logic                  stall,
  output logic                  drn_valid,
  input  logic                  drn_ready,
  output logic [ID_W-1:0]       drn_id,
  output logic [ADDR_W-1:0]     drn_addr,
  output logic [DATA_W-1:0]     drn_data,
  input  logic                  ack_valid,
  input  logic [ID_W-1:0]       ack_id,
  output logic [(1<<ID_W)-1:0]  local_durable
);
  import pb_pkg::*;

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int EP_W  = $clog2(DEPTH) + 1;

  typedef struct packed {
    logic              vld;
    kind_e             kind;
    logic              sent;
    logic [EP_W-1:0]   ep;
    logic [ID_W-1:0]   id;
    logic              dep;
    logic [ID_W-1:0]   dep_id;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } ent_t;

  ent_t              ent_q [DEPTH];
  ent_t              ent_d [DEPTH];
  logic [ID_W-1:0]   id_q, id_d;
  logic [EP_W-1:0]   ep_q, ep_d, head_q, head_d;
  logic              pdep_q, pdep_d;
  logic [ID_W-1:0]   pdep_id_q, pdep_id_d;
  logic              drn_vld_q, drn_vld_d;
  logic [IDX_W-1:0]  drn_idx_q, drn_idx_d;

  logic [DEPTH-1:0]  free_req, elig, head_live, mark_hit, ack_hit, vld_mask;
  logic              free_any, elig_any;
  logic [IDX_W-1:0]  free_idx, elig_idx;
  logic              persist_st, want, alloc, alloc_st, alloc_fn;
  logic              mark_ret, hs, ack_any;

  // slot state classification
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      vld_mask[i]  = ent_q[i].vld;
      free_req[i]  = !ent_q[i].vld;
      head_live[i] = ent_q[i].vld && ent_q[i].kind == KIND_STORE && ent_q[i].ep == head_q;
      mark_hit[i]  = ent_q[i].vld && ent_q[i].kind == KIND_FENCE && ent_q[i].ep == head_q;
      elig[i]      = head_live[i] && !ent_q[i].sent &&
                     (!ent_q[i].dep || remote_durable[ent_q[i].dep_id]);
      ack_hit[i]   = ack_valid && ent_q[i].vld && ent_q[i].kind == KIND_STORE &&
                     ent_q[i].sent && ent_q[i].id == ack_id;
    end
  end

  pb_pick #(.N(DEPTH)) u_free_pick (.req(free_req), .any(free_any), .idx(free_idx));
  pb_pick #(.N(DEPTH)) u_drn_pick  (.req(elig),     .any(elig_any), .idx(elig_idx));

  always_comb begin
    persist_st = st_valid && st_addr[ADDR_W-1];
    want       = persist_st || fence_valid;
    stall      = want && !free_any;
    alloc      = want && free_any;
    alloc_st   = alloc && persist_st;
    alloc_fn   = alloc && !persist_st;
    mark_ret   = (|mark_hit) && !(|head_live);
    hs         = drn_vld_q && drn_ready;
    ack_any    = |ack_hit;
  end

  // entry next state
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      ent_d[i] = ent_q[i];
      if (hs && drn_idx_q == IDX_W'(i)) ent_d[i].sent = 1'b1;
      if (ack_hit[i])                   ent_d[i].vld  = 1'b0;
      if (mark_ret && mark_hit[i])      ent_d[i].vld  = 1'b0;
      if (alloc && free_idx == IDX_W'(i)) begin
        ent_d[i].vld    = 1'b1;
        ent_d[i].kind   = alloc_st ? KIND_STORE : KIND_FENCE;
        ent_d[i].sent   = 1'b0;
        ent_d[i].ep     = ep_q;
        ent_d[i].id     = id_q;
        ent_d[i].dep    = alloc_st && pdep_q;
        ent_d[i].dep_id = pdep_id_q;
        ent_d[i].addr   = alloc_st ? st_addr : '0;
        ent_d[i].data   = alloc_st ? st_data : '0;
      end
    end
  end

  // counters, pending dependency and drain request next state
  always_comb begin
    id_d      = id_q + ID_W'(alloc_st);
    ep_d      = ep_q + EP_W'(alloc_fn);
    head_d    = head_q + EP_W'(mark_ret);
    pdep_d    = pdep_q;
    pdep_id_d = pdep_id_q;
    if (snoop_dep_valid) begin
      pdep_d    = 1'b1;
      pdep_id_d = snoop_dep_id;
    end else if (alloc_st) begin
      pdep_d    = 1'b0;
    end
    drn_vld_d = drn_vld_q;
    drn_idx_d = drn_idx_q;
    if (drn_vld_q) begin
      if (drn_ready) drn_vld_d = 1'b0;
    end else if (elig_any) begin
      drn_vld_d = 1'b1;
      drn_idx_d = elig_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
      id_q      <= '0;
      ep_q      <= '0;
      head_q    <= '0;
      pdep_q    <= 1'b0;
      pdep_id_q <= '0;
      drn_vld_q <= 1'b0;
      drn_idx_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= ent_d[i];
      if (alloc_st)                  id_q      <= id_d;
      if (alloc_fn)                  ep_q      <= ep_d;
      if (mark_ret)                  head_q    <= head_d;
      if (snoop_dep_valid || alloc_st) begin
        pdep_q    <= pdep_d;
        pdep_id_q <= pdep_id_d;
      end
      drn_vld_q <= drn_vld_d;
      if (!drn_vld_q)                drn_idx_q <= drn_idx_d;
    end
  end

  pb_durable #(.ID_W(ID_W)) u_durable (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_en (alloc_st),
    .clr_id (id_q),
    .set_en (ack_any),
    .set_id (ack_id),
    .done   (local_durable)
  );

  always_comb begin
    drn_valid = drn_vld_q;
    drn_id    = ent_q[drn_idx_q].id;
    drn_addr  = ent_q[drn_idx_q].addr;
    drn_data  = ent_q[drn_idx_q].data;
  end
endmodule

// File: rtl/pb_checker.sv
module pb_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int ID_W   = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  st_valid,
  input logic [ADDR_W-1:0]     st_addr,
  input logic                  fence_valid,
  input logic                  stall,
  input logic                  drn_valid,
  input logic                  drn_ready,
  input logic [ID_W-1:0]       drn_id,
  input logic [ADDR_W-1:0]     drn_addr,
  input logic [DATA_W-1:0]     drn_data,
  input logic                  ack_valid,
  input logic [(1<<ID_W)-1:0]  local_durable,
  input logic                  free_any,
  input logic [ID_W-1:0]       id_q,
  input logic [DEPTH-1:0]      vld_mask
);
  p_empty_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_mask == '0 && !drn_valid) |=> !drn_valid);

  p_volatile_no_id_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_addr[ADDR_W-1] && !fence_valid) |=> id_q == $past(id_q));

  p_drain_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (drn_valid && !drn_ready) |=> drn_valid && $stable(drn_id) &&
                                  $stable(drn_addr) && $stable(drn_data));

  p_stall_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> ((st_valid && st_addr[ADDR_W-1]) || fence_valid));

  p_stall_space_r8: assert property (@(posedge clk) disable iff (!rst_n)
    free_any |-> !stall);

  p_durable_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((local_durable & ~$past(local_durable)) != '0) |-> $past(ack_valid));
endmodule

bind persist_buffer pb_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .ID_W(ID_W)
) u_pb_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .st_valid      (st_valid),
  .st_addr       (st_addr),
  .fence_valid   (fence_valid),
  .stall         (stall),
  .drn_valid     (drn_valid),
  .drn_ready     (drn_ready),
  .drn_id        (drn_id),
  .drn_addr      (drn_addr),
  .drn_data      (drn_data),
  .ack_valid     (ack_valid),
  .local_durable (local_durable),
  .free_any      (free_any),
  .id_q          (id_q),
  .vld_mask      (vld_mask)
);

// File: tb/persist_buffer_bench.sv
module persist_buffer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 8;
  localparam int ID_W   = 4;
  localparam int NID    = 1 << ID_W;

  logic              clk;
  logic              rst_n;
  logic              st_valid;
  logic [ADDR_W-1:0] st_addr;
  logic [DATA_W-1:0] st_data;
  logic              fence_valid;
  logic              snoop_dep_valid;
  logic [ID_W-1:0]   snoop_dep_id;
  logic [NID-1:0]    remote_durable;
  logic              stall;
  logic              drn_valid;
  logic              drn_ready;
  logic [ID_W-1:0]   drn_id;
  logic [ADDR_W-1:0] drn_addr;
  logic [DATA_W-1:0] drn_data;
  logic              ack_valid;
  logic [ID_W-1:0]   ack_id;
  logic [NID-1:0]    local_durable;

  int checks;
  int failures;
  bit done;

  persist_buffer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .ID_W(ID_W)) u_persist_buffer (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
    .fence_valid(fence_valid),
    .snoop_dep_valid(snoop_dep_valid), .snoop_dep_id(snoop_dep_id),
    .remote_durable(remote_durable),
    .stall(stall),
    .drn_valid(drn_valid), .drn_ready(drn_ready), .drn_id(drn_id),
    .drn_addr(drn_addr), .drn_data(drn_data),
    .ack_valid(ack_valid), .ack_id(ack_id),
    .local_durable(local_durable)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic put_store(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    st_valid = 1'b1; st_addr = a; st_data = d;
    tick();
    st_valid = 1'b0;
  endtask

  task automatic put_fence();
    fence_valid = 1'b1;
    tick();
    fence_valid = 1'b0;
  endtask

  task automatic wait_drain(string req, output bit found);
    found = 1'b0;
    for (int n = 0; n < 20; n++) begin
      if (drn_valid) begin found = 1'b1; break; end
      tick();
    end
    if (!found) check(req, "drain never offered", 64'd0, 64'd1);
  endtask

  task automatic handshake();
    drn_ready = 1'b1;
    tick();
    drn_ready = 1'b0;
  endtask

  task automatic take(string req, logic [ID_W-1:0] eid, logic [ADDR_W-1:0] ea, logic [DATA_W-1:0] ed);
    bit found;
    wait_drain(req, found);
    if (found) begin
      check(req, "drain id", 64'(drn_id), 64'(eid));
      check(req, "drain addr", 64'(drn_addr), 64'(ea));
      check(req, "drain data", 64'(drn_data), 64'(ed));
      handshake();
    end
  endtask

  task automatic take_any(string req, output logic [ID_W-1:0] got);
    bit found;
    got = '0;
    wait_drain(req, found);
    if (found) begin
      got = drn_id;
      handshake();
    end
  endtask

  task automatic do_ack(logic [ID_W-1:0] id);
    ack_valid = 1'b1; ack_id = id;
    tick();
    ack_valid = 1'b0;
  endtask

  task automatic quiet(string req, int n);
    int seen = 0;
    for (int k = 0; k < n; k++) begin
      if (drn_valid) seen++;
      tick();
    end
    check(req, "cycles with drain offered", 64'(seen), 64'd0);
  endtask

  // R1
  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    check("R1", "stall after reset", 64'(stall), 64'd0);
    check("R1", "drn_valid after reset", 64'(drn_valid), 64'd0);
    check("R1", "durable vector after reset", 64'(local_durable), 64'd0);
    quiet("R1", 3);
  endtask

  // R2 R3 R4 R9
  task automatic t_single();
    bit found;
    logic [ID_W-1:0] id0;
    logic [ADDR_W-1:0] a0;
    logic [DATA_W-1:0] d0;
    int moved = 0;
    put_store(16'h0100, 32'hDEAD_0000);
    quiet("R3", 5);
    put_store(16'h8010, 32'hA5A5_0001);
    wait_drain("R2", found);
    if (found) begin
      id0 = drn_id; a0 = drn_addr; d0 = drn_data;
      check("R2", "first id (volatile took none, R3)", 64'(id0), 64'd0);
      check("R2", "first addr", 64'(a0), 64'h8010);
      check("R2", "first data", 64'(d0), 64'hA5A5_0001);
      for (int k = 0; k < 3; k++) begin
        tick();
        if (!drn_valid || drn_id !== id0 || drn_addr !== a0 || drn_data !== d0) moved++;
      end
      check("R4", "changes while stalled", 64'(moved), 64'd0);
      handshake();
    end
    do_ack(4'd0);
    check("R9", "durable bit 0 after ack", 64'(local_durable[0]), 64'd1);
  endtask

  // R5
  task automatic t_epoch();
    put_store(16'h8020, 32'h0000_1111);
    put_fence();
    check("R8", "fence with space does not stall", 64'(stall), 64'd0);
    put_store(16'h8030, 32'h0000_2222);
    take("R5", 4'd1, 16'h8020, 32'h0000_1111);
    quiet("R5", 6);
    do_ack(4'd1);
    take("R5", 4'd2, 16'h8030, 32'h0000_2222);
    do_ack(4'd2);
  endtask

  // R6 R9
  task automatic t_intra();
    put_store(16'h8040, 32'h0000_3333);
    put_store(16'h8050, 32'h0000_4444);
    take("R6", 4'd3, 16'h8040, 32'h0000_3333);
    take("R6", 4'd4, 16'h8050, 32'h0000_4444);
    do_ack(4'd4);
    do_ack(4'd3);
    check("R9", "durable bits 3 and 4", 64'(local_durable[4:3]), 64'd3);
  endtask

  // R7
  task automatic t_dep();
    snoop_dep_valid = 1'b1; snoop_dep_id = 4'd5;
    tick();
    snoop_dep_valid = 1'b0;
    put_store(16'h8060, 32'h0000_5555);
    quiet("R7", 6);
    remote_durable[5] = 1'b1;
    take("R7", 4'd5, 16'h8060, 32'h0000_5555);
    do_ack(4'd5);
  endtask

  // R8 R10 R9
  task automatic t_full();
    logic [ID_W-1:0] got;
    logic [NID-1:0] seen = '0;
    for (int k = 0; k < DEPTH; k++) put_store(ADDR_W'(16'h8100 + k), DATA_W'(k));
    st_valid = 1'b1; st_addr = 16'h8200; st_data = 32'h0000_7777;
    #1 check("R8", "persistent store when full", 64'(stall), 64'd1);
    st_addr = 16'h0200;
    #1 check("R8", "volatile store when full", 64'(stall), 64'd0);
    st_valid = 1'b0; fence_valid = 1'b1;
    #1 check("R8", "fence when full", 64'(stall), 64'd1);
    fence_valid = 1'b0; st_valid = 1'b1; st_addr = 16'h8200;
    tick();
    take("R6", 4'd6, 16'h8100, 32'd0);
    do_ack(4'd6);
    check("R10", "stall released after ack", 64'(stall), 64'd0);
    tick();
    st_valid = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      take_any("R10", got);
      seen[got] = 1'b1;
      do_ack(got);
    end
    check("R10", "ids drained after refill", 64'(seen), 64'h7F80);
    check("R9", "durable bits 7..14", 64'(local_durable[14:7]), 64'hFF);
  endtask

  // R2 R9
  task automatic t_wrap();
    put_store(16'h8300, 32'h0000_AAAA);
    put_store(16'h8310, 32'h0000_BBBB);
    check("R9", "durable bit 0 cleared by reuse", 64'(local_durable[0]), 64'd0);
    take("R2", 4'd15, 16'h8300, 32'h0000_AAAA);
    take("R2", 4'd0, 16'h8310, 32'h0000_BBBB);
    do_ack(4'd0);
    do_ack(4'd15);
    check("R9", "durable bits 0 and 15", 64'({local_durable[15], local_durable[0]}), 64'd3);
  endtask

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    rst_n = 1'b0;
    st_valid = 1'b0; st_addr = '0; st_data = '0;
    fence_valid = 1'b0;
    snoop_dep_valid = 1'b0; snoop_dep_id = '0;
    remote_durable = '0;
    drn_ready = 1'b0;
    ack_valid = 1'b0; ack_id = '0;
    t_reset();
    t_single();
    t_epoch();
    t_intra();
    t_dep();
    t_full();
    t_wrap();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule